// File: doc/BRIEF.md
# Interrupt Context and Designator Unit

This block keeps the processor's context designators: a 4-bit index naming the register that acts as program counter, a 4-bit index naming the register that acts as data pointer, an 8-bit holding register for a saved context, and the interrupt-enable flag. The block owns no register file and no memory timing. It tells its neighbours which register to address, which byte to write, and which register index to bump up or down.

A sequencer drives one decoded operation per cycle, or an interrupt acknowledge once the current instruction has finished. On an acknowledge the two designators are packed into the holding register, and fixed service values are forced in. No vector is fetched and no program counter is pushed. The context instructions cover four cases. Save writes the holding register out. Mark packs the designators, stores them through register 2 and moves the program designator into the data designator. Return and disable reload both designators from a memory byte and set or clear the enable flag.

Memory and pointer requests are combinational in the cycle of the operation. Register state changes at the next clock edge.

Top module: `ctx_unit`

## Requirements
- R1: While rst_ni is low, x_o, p_o and t_o are 0 and ie_o is 1.
- R2: clr_i sets ie_o to 1 at the next edge and leaves x_o, p_o and t_o unchanged. In that cycle the acknowledge and the operation are ignored.
- R3: init_i clears x_o and p_o to 0 at the next edge and leaves t_o unchanged. In that cycle the acknowledge and the operation are ignored. If clr_i is high in the same cycle, R2 also applies.
- R4: int_ack_i with ie_o = 1 loads t_o with {x_o, p_o} (data designator in bits 7:4), x_o with 2 and p_o with 1, and clears ie_o, all at the next edge. It raises no memory write and no pointer request.
- R5: int_ack_i with ie_o = 0 has no effect: the operation on op_i proceeds as if no acknowledge were present.
- R6: An acknowledge that is taken (R4) overrides op_i. The operation causes no state change and no request.
- R7: Save (op_i = 1) raises mem_we_o with mem_wdata_o = t_o and mem_ptr_o = x_o in the same cycle. It changes no state.
- R8: Mark (op_i = 2) raises mem_we_o with mem_wdata_o = {x_o, p_o} and mem_ptr_o = 2. It pulses ptr_dec_o with ptr_dec_idx_o = 2 in the same cycle. At the next edge t_o becomes {x_o, p_o} and x_o takes the old p_o.
- R9: Return (op_i = 3) reads through mem_ptr_o = x_o and pulses ptr_inc_o with ptr_inc_idx_o = x_o in the same cycle. At the next edge x_o becomes mem_rdata_i[7:4], p_o becomes mem_rdata_i[3:0] and ie_o becomes 1.
- R10: Disable (op_i = 4) behaves as Return, but ie_o becomes 0.
- R11: With op_i = 0 and no strobe, no request is raised and all state holds.
- R12: op_i codes 5, 6 and 7 behave exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous reset strobe; sets the enable flag |
| init_i | input | 1 | Initialization strobe; clears both designators |
| int_ack_i | input | 1 | Interrupt acknowledge from the sequencer |
| op_i | input | 3 | Decoded operation: 0 none, 1 save, 2 mark, 3 return, 4 disable |
| mem_rdata_i | input | 8 | Memory byte read for return and disable |
| x_o | output | 4 | Data-pointer designator |
| p_o | output | 4 | Program-counter designator |
| t_o | output | 8 | Saved context byte |
| ie_o | output | 1 | Interrupt enable |
| mem_we_o | output | 1 | Memory write request |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_ptr_o | output | 4 | Index of the register that addresses memory |
| ptr_inc_o | output | 1 | Register increment pulse |
| ptr_inc_idx_o | output | 4 | Register index to increment |
| ptr_dec_o | output | 1 | Register decrement pulse |
| ptr_dec_idx_o | output | 4 | Register index to decrement |

## Verification
Memory write, pointer index and increment/decrement results are due in the same cycle as the operation. The bench drives inputs at the falling edge and compares these outputs one nanosecond later, before the rising edge. Designator, holding-register and enable results are due one rising edge after the stimulus. The bench samples them two nanoseconds after that edge, against a model it advances only at that point. Each compared cycle is tagged with the requirement set by its strobe priority and opcode.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  localparam int CTX_NIB_W = 4;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_SAV  = 3'd1,
    OP_MARK = 3'd2,
    OP_RET  = 3'd3,
    OP_DIS  = 3'd4
  } ctx_op_e;
endpackage

// File: rtl/ctx_decode.sv
module ctx_decode
  import ctx_pkg::*;
#(
  parameter int NIB_W    = CTX_NIB_W,
  parameter int INT_X    = 2,
  parameter int INT_P    = 1,
  parameter int LINK_REG = 2,
  localparam int BYTE_W  = 2 * NIB_W
) (
  input  logic              clr_i,
  input  logic              init_i,
  input  logic              ack_i,
  input  logic              ie_i,
  input  logic [2:0]        op_i,
  input  logic [NIB_W-1:0]  x_i,
  input  logic [NIB_W-1:0]  p_i,
  input  logic [BYTE_W-1:0] t_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              ld_x_o,
  output logic              ld_p_o,
  output logic              ld_t_o,
  output logic              ld_ie_o,
  output logic [NIB_W-1:0]  x_nxt_o,
  output logic [NIB_W-1:0]  p_nxt_o,
  output logic [BYTE_W-1:0] t_nxt_o,
  output logic              ie_nxt_o,
  output logic              we_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic [NIB_W-1:0]  ptr_o,
  output logic              inc_o,
  output logic [NIB_W-1:0]  inc_idx_o,
  output logic              dec_o,
  output logic [NIB_W-1:0]  dec_idx_o
);
  localparam logic [NIB_W-1:0] INT_X_V = NIB_W'(INT_X);
  localparam logic [NIB_W-1:0] INT_P_V = NIB_W'(INT_P);
  localparam logic [NIB_W-1:0] LINK_V  = NIB_W'(LINK_REG);

  ctx_op_e op;
  logic    take_int;

  assign take_int = ack_i && ie_i;

  always_comb begin
    op = OP_NONE;
    case (op_i)
      3'd1:    op = OP_SAV;
      3'd2:    op = OP_MARK;
      3'd3:    op = OP_RET;
      3'd4:    op = OP_DIS;
      default: op = OP_NONE;
    endcase
  end

  always_comb begin
    ld_x_o    = 1'b0;
    ld_p_o    = 1'b0;
    ld_t_o    = 1'b0;
    ld_ie_o   = 1'b0;
    x_nxt_o   = x_i;
    p_nxt_o   = p_i;
    t_nxt_o   = t_i;
    ie_nxt_o  = ie_i;
    we_o      = 1'b0;
    wdata_o   = t_i;
    ptr_o     = x_i;
    inc_o     = 1'b0;
    inc_idx_o = x_i;
    dec_o     = 1'b0;
    dec_idx_o = LINK_V;
    if (clr_i || init_i) begin
      if (clr_i) begin
        ld_ie_o  = 1'b1;
        ie_nxt_o = 1'b1;
      end
      if (init_i) begin
        ld_x_o  = 1'b1;
        ld_p_o  = 1'b1;
        x_nxt_o = '0;
        p_nxt_o = '0;
      end
    end else if (take_int) begin
      // context packed before fixed service designators are forced
      ld_t_o   = 1'b1;
      t_nxt_o  = {x_i, p_i};
      ld_x_o   = 1'b1;
      x_nxt_o  = INT_X_V;
      ld_p_o   = 1'b1;
      p_nxt_o  = INT_P_V;
      ld_ie_o  = 1'b1;
      ie_nxt_o = 1'b0;
    end else begin
      case (op)
        OP_SAV: begin
          we_o    = 1'b1;
          wdata_o = t_i;
        end
        OP_MARK: begin
          we_o    = 1'b1;
          wdata_o = {x_i, p_i};
          ptr_o   = LINK_V;
          dec_o   = 1'b1;
          ld_t_o  = 1'b1;
          t_nxt_o = {x_i, p_i};
          ld_x_o  = 1'b1;
          x_nxt_o = p_i;
        end
        OP_RET, OP_DIS: begin
          inc_o    = 1'b1;
          ld_x_o   = 1'b1;
          ld_p_o   = 1'b1;
          x_nxt_o  = rdata_i[BYTE_W-1:NIB_W];
          p_nxt_o  = rdata_i[NIB_W-1:0];
          ld_ie_o  = 1'b1;
          ie_nxt_o = (op == OP_RET);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ctx_regs.sv
module ctx_regs #(
  parameter int NIB_W   = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_x_i,
  input  logic              ld_p_i,
  input  logic              ld_t_i,
  input  logic              ld_ie_i,
  input  logic [NIB_W-1:0]  x_nxt_i,
  input  logic [NIB_W-1:0]  p_nxt_i,
  input  logic [BYTE_W-1:0] t_nxt_i,
  input  logic              ie_nxt_i,
  output logic [NIB_W-1:0]  x_o,
  output logic [NIB_W-1:0]  p_o,
  output logic [BYTE_W-1:0] t_o,
  output logic              ie_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o  <= '0;
      p_o  <= '0;
      t_o  <= '0;
      ie_o <= 1'b1;
    end else begin
      if (ld_x_i)  x_o  <= x_nxt_i;
      if (ld_p_i)  p_o  <= p_nxt_i;
      if (ld_t_i)  t_o  <= t_nxt_i;
      if (ld_ie_i) ie_o <= ie_nxt_i;
    end
  end
endmodule

// File: rtl/ctx_unit.sv
module ctx_unit
  import ctx_pkg::*;
#(
  parameter int NIB_W    = CTX_NIB_W,
  parameter int INT_X    = 2,
  parameter int INT_P    = 1,
  parameter int LINK_REG = 2,
  localparam int BYTE_W  = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              init_i,
  input  logic              int_ack_i,
  input  logic [2:0]        op_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [NIB_W-1:0]  x_o,
  output logic [NIB_W-1:0]  p_o,
  output logic [BYTE_W-1:0] t_o,
  output logic              ie_o,
  output logic              mem_we_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic [NIB_W-1:0]  mem_ptr_o,
  output logic              ptr_inc_o,
  output logic [NIB_W-1:0]  ptr_inc_idx_o,
  output logic              ptr_dec_o,
  output logic [NIB_W-1:0]  ptr_dec_idx_o
);
  logic              ld_x, ld_p, ld_t, ld_ie;
  logic [NIB_W-1:0]  x_nxt, p_nxt;
  logic [BYTE_W-1:0] t_nxt;
  logic              ie_nxt;

  ctx_decode #(
    .NIB_W(NIB_W), .INT_X(INT_X), .INT_P(INT_P), .LINK_REG(LINK_REG)
  ) u_dec (
    .clr_i     (clr_i),
    .init_i    (init_i),
    .ack_i     (int_ack_i),
    .ie_i      (ie_o),
    .op_i      (op_i),
    .x_i       (x_o),
    .p_i       (p_o),
    .t_i       (t_o),
    .rdata_i   (mem_rdata_i),
    .ld_x_o    (ld_x),
    .ld_p_o    (ld_p),
    .ld_t_o    (ld_t),
    .ld_ie_o   (ld_ie),
    .x_nxt_o   (x_nxt),
    .p_nxt_o   (p_nxt),
    .t_nxt_o   (t_nxt),
    .ie_nxt_o  (ie_nxt),
    .we_o      (mem_we_o),
    .wdata_o   (mem_wdata_o),
    .ptr_o     (mem_ptr_o),
    .inc_o     (ptr_inc_o),
    .inc_idx_o (ptr_inc_idx_o),
    .dec_o     (ptr_dec_o),
    .dec_idx_o (ptr_dec_idx_o)
  );

  ctx_regs #(.NIB_W(NIB_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_x_i   (ld_x),
    .ld_p_i   (ld_p),
    .ld_t_i   (ld_t),
    .ld_ie_i  (ld_ie),
    .x_nxt_i  (x_nxt),
    .p_nxt_i  (p_nxt),
    .t_nxt_i  (t_nxt),
    .ie_nxt_i (ie_nxt),
    .x_o      (x_o),
    .p_o      (p_o),
    .t_o      (t_o),
    .ie_o     (ie_o)
  );
endmodule

// File: rtl/ctx_unit_chk.sv
module ctx_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clr_i,
  input logic       init_i,
  input logic       int_ack_i,
  input logic [2:0] op_i,
  input logic [7:0] mem_rdata_i,
  input logic [3:0] x_o,
  input logic [3:0] p_o,
  input logic [7:0] t_o,
  input logic       ie_o,
  input logic       mem_we_o,
  input logic [7:0] mem_wdata_o,
  input logic [3:0] mem_ptr_o,
  input logic       ptr_inc_o,
  input logic [3:0] ptr_inc_idx_o,
  input logic       ptr_dec_o,
  input logic [3:0] ptr_dec_idx_o
);
  logic quiet, taken;
  assign quiet = !clr_i && !init_i;
  assign taken = quiet && int_ack_i && ie_o;

  // R2
  clr_sets_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ie_o && $stable(t_o));

  // R3
  init_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> x_o == 4'd0 && p_o == 4'd0);

  // R4
  ack_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken |=> x_o == 4'd2 && p_o == 4'd1 && !ie_o && t_o == {$past(x_o), $past(p_o)});

  // R6
  ack_blocks_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken |-> !mem_we_o && !ptr_inc_o && !ptr_dec_o);

  // R7
  save_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && !taken && op_i == 3'd1) |-> mem_we_o && mem_wdata_o == t_o && mem_ptr_o == x_o);

  // R8
  mark_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_dec_o |-> ptr_dec_idx_o == 4'd2 && mem_ptr_o == 4'd2 && mem_we_o);

  // R9
  ret_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && !taken && op_i == 3'd3) |=> {x_o, p_o} == $past(mem_rdata_i) && ie_o);

  // R9
  ret_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && !taken && op_i == 3'd3) |-> ptr_inc_o && ptr_inc_idx_o == x_o && !mem_we_o);

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && !int_ack_i && op_i == 3'd0) |=> $stable(x_o) && $stable(p_o) && $stable(t_o) && $stable(ie_o));

  // R11
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ptr_inc_o && ptr_dec_o));
endmodule

bind ctx_unit ctx_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .init_i(init_i),
  .int_ack_i(int_ack_i), .op_i(op_i), .mem_rdata_i(mem_rdata_i),
  .x_o(x_o), .p_o(p_o), .t_o(t_o), .ie_o(ie_o), .mem_we_o(mem_we_o),
  .mem_wdata_o(mem_wdata_o), .mem_ptr_o(mem_ptr_o), .ptr_inc_o(ptr_inc_o),
  .ptr_inc_idx_o(ptr_inc_idx_o), .ptr_dec_o(ptr_dec_o), .ptr_dec_idx_o(ptr_dec_idx_o)
);

// File: tb/tb_ctx_unit.sv
`timescale 1ns/1ps
module tb_ctx_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_i = 1'b0, init_i = 1'b0, int_ack_i = 1'b0;
  logic [2:0] op_i = 3'd0;
  logic [7:0] mem_rdata_i = 8'd0;
  logic [3:0] x_o, p_o, mem_ptr_o, ptr_inc_idx_o, ptr_dec_idx_o;
  logic [7:0] t_o, mem_wdata_o;
  logic       ie_o, mem_we_o, ptr_inc_o, ptr_dec_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [3:0] mx, mp;
  logic [7:0] mt;
  logic       mie;

  always #5 clk_i = ~clk_i;

  ctx_unit dut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk(x_o == mx,   tag, "x",  int'(x_o),  int'(mx));
    chk(p_o == mp,   tag, "p",  int'(p_o),  int'(mp));
    chk(t_o == mt,   tag, "t",  int'(t_o),  int'(mt));
    chk(ie_o == mie, tag, "ie", int'(ie_o), int'(mie));
  endtask

  function automatic string tag_of(input bit c, input bit in, input bit a,
                                   input bit ie, input logic [2:0] op);
    if (c) return "R2";
    if (in) return "R3";
    if (a && ie) return (op != 3'd0) ? "R6" : "R4";
    if (a) return "R5";
    case (op)
      3'd1: return "R7";
      3'd2: return "R8";
      3'd3: return "R9";
      3'd4: return "R10";
      3'd0: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic step(input bit c, input bit in, input bit a,
                      input logic [2:0] op, input logic [7:0] rd);
    string tag;
    bit e_we, e_inc, e_dec, run;
    logic [7:0] e_wd;
    logic [3:0] e_ptr;
    @(negedge clk_i);
    clr_i = c; init_i = in; int_ack_i = a; op_i = op; mem_rdata_i = rd;
    #1;
    tag = tag_of(c, in, a, mie, op);
    run = !c && !in && !(a && mie);
    e_we  = run && (op == 3'd1 || op == 3'd2);
    e_inc = run && (op == 3'd3 || op == 3'd4);
    e_dec = run && (op == 3'd2);
    e_wd  = (op == 3'd2) ? {mx, mp} : mt;
    e_ptr = (e_dec) ? 4'd2 : mx;
    chk(mem_we_o == e_we,   tag, "we",  int'(mem_we_o),  int'(e_we));
    chk(ptr_inc_o == e_inc, tag, "inc", int'(ptr_inc_o), int'(e_inc));
    chk(ptr_dec_o == e_dec, tag, "dec", int'(ptr_dec_o), int'(e_dec));
    if (e_we) begin
      chk(mem_wdata_o == e_wd, tag, "wdata", int'(mem_wdata_o), int'(e_wd));
      chk(mem_ptr_o == e_ptr,  tag, "ptr",   int'(mem_ptr_o),   int'(e_ptr));
    end
    if (e_inc) begin
      chk(ptr_inc_idx_o == mx, tag, "inc_idx", int'(ptr_inc_idx_o), int'(mx));
      chk(mem_ptr_o == mx,     tag, "ptr",     int'(mem_ptr_o),     int'(mx));
    end
    if (e_dec)
      chk(ptr_dec_idx_o == 4'd2, tag, "dec_idx", int'(ptr_dec_idx_o), 2);
    @(posedge clk_i);
    #2;
    if (c || in) begin
      if (c) mie = 1'b1;
      if (in) begin mx = 4'd0; mp = 4'd0; end
    end else if (a && mie) begin
      mt = {mx, mp}; mx = 4'd2; mp = 4'd1; mie = 1'b0;
    end else begin
      case (op)
        3'd2: begin mt = {mx, mp}; mx = mp; end
        3'd3: begin mx = rd[7:4]; mp = rd[3:0]; mie = 1'b1; end
        3'd4: begin mx = rd[7:4]; mp = rd[3:0]; mie = 1'b0; end
        default: ;
      endcase
    end
    chk_state(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1802));
    mx = 4'd0; mp = 4'd0; mt = 8'd0; mie = 1'b1;
    #12;
    // R1: reset values held while rst_ni low
    chk_state("R1");
    @(negedge clk_i); rst_ni = 1'b1;
    // directed corners
    step(0, 0, 0, 3'd3, 8'h5A);   // R9 return loads 5/A, ie 1
    step(0, 0, 1, 3'd0, 8'h00);   // R4 entry: t=5A, x2 p1 ie0
    step(0, 0, 1, 3'd3, 8'hC3);   // R5 ack ignored with ie 0, return proceeds
    step(0, 0, 1, 3'd2, 8'h00);   // R6 ack wins over mark
    step(0, 0, 0, 3'd1, 8'h00);   // R7 save
    step(0, 0, 0, 3'd2, 8'h00);   // R8 mark
    step(0, 0, 0, 3'd4, 8'h97);   // R10 disable
    step(0, 0, 1, 3'd0, 8'h00);   // R5 ack with ie 0
    step(0, 0, 0, 3'd7, 8'hFF);   // R12 unused code
    step(0, 0, 0, 3'd5, 8'hFF);   // R12
    step(1, 0, 1, 3'd3, 8'h11);   // R2 clr blocks ack and op
    step(0, 1, 1, 3'd2, 8'h22);   // R3 init blocks ack and op
    step(1, 1, 0, 3'd4, 8'h33);   // R2 and R3 together
    step(0, 0, 0, 3'd0, 8'h44);   // R11 idle
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 40) == 0, ($urandom % 40) == 0, ($urandom % 4) == 0,
           3'($urandom % 8), 8'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule